// File: doc/BRIEF.md
# Clash-Minimising Test Pair Scheduler

This block takes a set of up to `NUM_PAIRS` test patterns, each with its expected response, and works out the order in which to apply them to a scan chain. The goal is to reduce shift power. A "clash" happens when the last response bit shifted out differs from the first bit of the next pattern shifted in. Each clash toggles every cell of the chain, so the cost in transitions is the number of clashes times the chain length. The scheduler groups the pairs so that consecutive boundary bits match as often as possible.

The pairs arrive one per beat on a load port. The index of a pair is its position in the load sequence, counting from 0. A strobe ends loading. Once loading has ended, the scheduler streams out the pair indices under a valid/ready handshake, one index per accepted beat. It raises a done flag when every loaded pair has been sent. Two counters report the number of clashes in the load order and in the emitted order, so the effect of reordering can be read directly.

Top module: `clash_sched`

## Requirements
- R1: The group code of a pair is {vector bit 0, response bit VEC_W-1}. Within one group, indices are emitted in the order they were loaded. The index of a pair is its load position, starting at 0.
- R2: All pairs of group 00 are emitted first.
- R3: Next comes exactly one pair of group 01, if group 01 holds any. If it holds none, this step is skipped.
- R4: Next come all pairs of group 11.
- R5: The remaining pairs are taken alternately from group 10 and group 01, starting with group 10. When either group runs out, the rest of the other group is emitted back to back.
- R6: Load beats are accepted only between reset and the end-of-load strobe, and at most NUM_PAIRS of them. Extra beats and beats after the strobe have no effect. A beat in the same cycle as the strobe is still accepted.
- R7: `out_valid` is high only after the end-of-load strobe and only while unsent pairs remain. `out_idx` holds steady while `out_valid` is high and `out_ready` is low. Each accepted handshake removes exactly one index.
- R8: `out_done` rises once loading has ended and every loaded pair has been emitted. It then stays high while `out_valid` stays low.
- R9: `clash_in` counts the consecutive loaded pairs where the earlier response bit VEC_W-1 differs from the later vector bit 0. It is updated on the cycle after each accepted beat. The first pair adds nothing.
- R10: `clash_out` counts clashes in the same way over the emitted sequence. It is updated on the cycle after each handshake.
- R11: During and right after reset, `out_valid`, `out_done`, `clash_in` and `clash_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load beat present |
| ld_vec | input | VEC_W | Test pattern of the beat |
| ld_resp | input | VEC_W | Expected response of the beat |
| ld_done | input | 1 | End-of-load strobe |
| out_valid | output | 1 | An index is offered |
| out_ready | input | 1 | Consumer takes the offered index |
| out_idx | output | clog2(NUM_PAIRS) | Load position of the offered pair |
| out_done | output | 1 | All loaded pairs emitted |
| clash_in | output | clog2(NUM_PAIRS+1) | Clashes in load order |
| clash_out | output | clog2(NUM_PAIRS+1) | Clashes in emitted order |

## Verification
Nothing passes combinationally from an input to an output. `out_valid`, `out_idx` and `out_done` follow the strobe or a handshake one clock edge later, and both clash counters change on the edge after the beat or handshake that affects them. The bench model updates on the same rising edge as the design and compares every output on the falling edge that follows. A result is therefore checked exactly one edge after the stimulus that causes it. Full sequences are also recorded at each handshake and compared with hand-derived orders, including the drain case, the skipped single pick, overflow and an empty load.

// File: rtl/clash_sched_pkg.sv
`timescale 1ns/1ps
package clash_sched_pkg;
   typedef logic [1:0] grp_t;
   localparam grp_t G00 = 2'b00;
   localparam grp_t G01 = 2'b01;
   localparam grp_t G10 = 2'b10;
   localparam grp_t G11 = 2'b11;
   localparam int   NGRP = 4;
endpackage

// File: rtl/cs_idx_fifo.sv
`timescale 1ns/1ps
module cs_idx_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("cs_idx_fifo: DEPTH must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign do_push = push && (cnt != CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/cs_pick.sv
`timescale 1ns/1ps
module cs_pick
   import clash_sched_pkg::*;
(
   input  logic [NGRP-1:0] empty,
   input  logic            took01,
   input  logic            alt01,
   output grp_t            sel,
   output logic            any
);
   always_comb begin
      any = 1'b1;
      sel = G00;
      if (!empty[G00])                      sel = G00;
      else if (!took01 && !empty[G01])      sel = G01;
      else if (!empty[G11])                 sel = G11;
      else if (!empty[G10] && !empty[G01])  sel = alt01 ? G01 : G10;
      else if (!empty[G10])                 sel = G10;
      else if (!empty[G01])                 sel = G01;
      else                                  any = 1'b0;
   end
endmodule

// File: rtl/cs_clash_cnt.sv
`timescale 1ns/1ps
module cs_clash_cnt #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          stb,
   input  logic          lsb,
   input  logic          msb,
   output logic [CW-1:0] count
);
   logic have_prev, prev_msb;

   always_ff @(posedge clk) begin
      if (rst) begin
         have_prev <= 1'b0;
         prev_msb  <= 1'b0;
         count     <= '0;
      end else if (stb) begin
         have_prev <= 1'b1;
         prev_msb  <= msb;
         if (have_prev && (prev_msb != lsb)) count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/clash_sched.sv
`timescale 1ns/1ps
module clash_sched
   import clash_sched_pkg::*;
#(
   parameter int NUM_PAIRS = 8,
   parameter int VEC_W     = 4,
   localparam int IW = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
   localparam int CW = $clog2(NUM_PAIRS + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_valid,
   input  logic [VEC_W-1:0] ld_vec,
   input  logic [VEC_W-1:0] ld_resp,
   input  logic             ld_done,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [IW-1:0]    out_idx,
   output logic             out_done,
   output logic [CW-1:0]    clash_in,
   output logic [CW-1:0]    clash_out
);
   if (NUM_PAIRS < 2) begin : g_bad_pairs
      $error("clash_sched: NUM_PAIRS must be at least 2");
   end
   if (VEC_W < 2) begin : g_bad_width
      $error("clash_sched: VEC_W must be at least 2");
   end

   logic            emitting;
   logic [CW-1:0]   n_loaded;
   logic            took01, alt01;
   logic            accept, hs, any;
   grp_t            ld_grp, sel;
   logic [NGRP-1:0] empty;
   logic [IW-1:0]   head [NGRP];
   logic            unused_bits;

   assign unused_bits = ^{ld_vec[VEC_W-1:1], ld_resp[VEC_W-2:0]};

   assign ld_grp = {ld_vec[0], ld_resp[VEC_W-1]};
   assign accept = !emitting && ld_valid && (n_loaded < CW'(NUM_PAIRS));

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      cs_idx_fifo #(.DEPTH(NUM_PAIRS), .W(IW)) u_fifo (
         .clk   (clk),
         .rst   (rst),
         .push  (accept && (ld_grp == 2'(g))),
         .din   (IW'(n_loaded)),
         .pop   (hs && (sel == 2'(g))),
         .dout  (head[g]),
         .empty (empty[g])
      );
   end

   cs_pick u_pick (
      .empty  (empty),
      .took01 (took01),
      .alt01  (alt01),
      .sel    (sel),
      .any    (any)
   );

   assign out_valid = emitting && any;
   assign out_done  = emitting && !any;
   assign out_idx   = head[sel];
   assign hs        = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         emitting <= 1'b0;
         n_loaded <= '0;
         took01   <= 1'b0;
         alt01    <= 1'b0;
      end else begin
         if (accept) n_loaded <= n_loaded + 1'b1;
         if (!emitting && ld_done) emitting <= 1'b1;
         if (hs && sel == G01) begin
            if (!took01) took01 <= 1'b1;
            else         alt01  <= 1'b0;
         end
         if (hs && sel == G10) alt01 <= 1'b1;
      end
   end

   cs_clash_cnt #(.CW(CW)) u_cnt_in (
      .clk   (clk),
      .rst   (rst),
      .stb   (accept),
      .lsb   (ld_vec[0]),
      .msb   (ld_resp[VEC_W-1]),
      .count (clash_in)
   );

   cs_clash_cnt #(.CW(CW)) u_cnt_out (
      .clk   (clk),
      .rst   (rst),
      .stb   (hs),
      .lsb   (sel[1]),
      .msb   (sel[0]),
      .count (clash_out)
   );
endmodule

// File: rtl/clash_sched_chk.sv
`timescale 1ns/1ps
module clash_sched_chk #(
   parameter int NUM_PAIRS = 8,
   parameter int IW        = 3,
   parameter int CW        = 4
) (
   input logic          clk,
   input logic          rst,
   input logic          out_valid,
   input logic          out_ready,
   input logic [IW-1:0] out_idx,
   input logic          out_done,
   input logic [CW-1:0] clash_in,
   input logic [CW-1:0] clash_out
);
   logic [CW:0] n_hs;

   always_ff @(posedge clk) begin
      if (rst)                         n_hs <= '0;
      else if (out_valid && out_ready) n_hs <= n_hs + 1'b1;
   end

   // R7: an offered index is held until taken
   a_r7_hold_idx: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_idx));

   // R7: never more indices than pairs
   a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
      n_hs <= (CW+1)'(NUM_PAIRS));

   // R8: done is sticky
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
      out_done |=> out_done);

   // R8: nothing offered once done
   a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
      out_done |-> !out_valid);

   // R9: input clash count moves by at most one per cycle
   a_r9_in_step: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (clash_in == $past(clash_in)) || (clash_in == $past(clash_in) + CW'(1)));

   // R10: output clash count moves by at most one per cycle
   a_r10_out_step: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (clash_out == $past(clash_out)) || (clash_out == $past(clash_out) + CW'(1)));

   // R10: a clash needs a handshake behind it
   a_r10_out_bound: assert property (@(posedge clk) disable iff (rst)
      {1'b0, clash_out} <= n_hs);
endmodule

bind clash_sched clash_sched_chk #(.NUM_PAIRS(NUM_PAIRS), .IW(IW), .CW(CW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_idx   (out_idx),
   .out_done  (out_done),
   .clash_in  (clash_in),
   .clash_out (clash_out)
);

// File: tb/clash_sched_bench.sv
`timescale 1ns/1ps
module clash_sched_bench;
   localparam int N  = 8;
   localparam int W  = 4;
   localparam int IW = 3;
   localparam int CW = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic          rst, ld_valid, ld_done, out_ready;
   logic [W-1:0]  ld_vec, ld_resp;
   logic          out_valid, out_done;
   logic [IW-1:0] out_idx;
   logic [CW-1:0] clash_in, clash_out;

   clash_sched #(.NUM_PAIRS(N), .VEC_W(W)) u_clash_sched (
      .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_vec(ld_vec), .ld_resp(ld_resp),
      .ld_done(ld_done), .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
      .out_done(out_done), .clash_in(clash_in), .clash_out(clash_out)
   );

   int checks = 0, errors = 0, cyc = 0;
   bit bp_mode = 0;

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural reference
   bit m_lsb[$], m_msb[$];
   int order[$];
   int seen[$];
   bit m_emit;
   int pos, m_cin, m_cout;

   function automatic void build_order();
      int q0[$], q1[$], q2[$], q3[$];
      bit take10;
      for (int i = 0; i < m_lsb.size(); i++) begin
         case ({m_lsb[i], m_msb[i]})
            2'b00: q0.push_back(i);
            2'b01: q1.push_back(i);
            2'b10: q2.push_back(i);
            default: q3.push_back(i);
         endcase
      end
      order.delete();
      foreach (q0[i]) order.push_back(q0[i]);
      if (q1.size() > 0) order.push_back(q1.pop_front());
      foreach (q3[i]) order.push_back(q3[i]);
      take10 = 1;
      while (q1.size() > 0 || q2.size() > 0) begin
         if (q2.size() > 0 && (take10 || q1.size() == 0)) begin
            order.push_back(q2.pop_front()); take10 = 0;
         end else begin
            order.push_back(q1.pop_front()); take10 = 1;
         end
      end
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_lsb.delete(); m_msb.delete(); order.delete(); seen.delete();
         m_emit = 0; pos = 0; m_cin = 0; m_cout = 0;
      end else begin
         if (out_valid && out_ready) seen.push_back(int'(out_idx));
         if (m_emit && pos < order.size() && out_ready) begin
            if (pos > 0 && m_msb[order[pos-1]] != m_lsb[order[pos]]) m_cout++;
            pos++;
         end
         if (!m_emit && ld_valid && m_lsb.size() < N) begin
            if (m_lsb.size() > 0 && m_msb[m_msb.size()-1] != ld_vec[0]) m_cin++;
            m_lsb.push_back(ld_vec[0]);
            m_msb.push_back(ld_resp[W-1]);
         end
         if (!m_emit && ld_done) begin
            build_order();
            m_emit = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         bit ev, ed;
         ev = m_emit && pos < order.size();
         ed = m_emit && pos == order.size();
         chk(out_valid == ev, "R7 out_valid", out_valid, ev);
         chk(out_done == ed, "R8 out_done", out_done, ed);
         if (ev && out_valid)
            chk(int'(out_idx) == order[pos], "R1/R2/R3/R4/R5 out_idx", out_idx, order[pos]);
         chk(int'(clash_in) == m_cin, "R9 clash_in", clash_in, m_cin);
         chk(int'(clash_out) == m_cout, "R10 clash_out", clash_out, m_cout);
      end
      out_ready <= bp_mode ? ((cyc % 3) != 0) : 1'b1;
   end

   task automatic beat(logic [W-1:0] v, logic [W-1:0] r);
      ld_valid = 1; ld_vec = v; ld_resp = r;
      @(negedge clk);
      ld_valid = 0;
   endtask

   task automatic end_load();
      ld_done = 1;
      @(negedge clk);
      ld_done = 0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!out_done && t < 300) begin @(negedge clk); t++; end
      chk(out_done, "R8 done reached", out_done, 1);
   endtask

   task automatic do_reset();
      rst = 1;
      repeat (2) @(negedge clk);
      rst = 0;
   endtask

   task automatic cmp_seq(string req, int exp[$]);
      chk(seen.size() == exp.size(), req, seen.size(), exp.size());
      if (seen.size() == exp.size())
         foreach (exp[i]) chk(seen[i] == exp[i], req, seen[i], exp[i]);
   endtask

   initial begin
      rst = 1; ld_valid = 0; ld_done = 0; ld_vec = '0; ld_resp = '0; out_ready = 1;
      repeat (3) @(negedge clk);
      chk(out_valid == 0, "R11 reset out_valid", out_valid, 0);
      chk(out_done == 0, "R11 reset out_done", out_done, 0);
      chk(clash_in == 0, "R11 reset clash_in", clash_in, 0);
      chk(clash_out == 0, "R11 reset clash_out", clash_out, 0);
      rst = 0;

      // worked example: 3 clashes in, 0 out
      beat(4'b0101, 4'b1001); beat(4'b1100, 4'b1000); beat(4'b0110, 4'b0011);
      beat(4'b1101, 4'b0000); beat(4'b0000, 4'b1001); beat(4'b1101, 4'b0101);
      beat(4'b0100, 4'b0001);
      chk(out_valid == 0, "R7 no output before strobe", out_valid, 0);
      end_load();
      wait_done();
      cmp_seq("R5 example order", '{2, 6, 1, 0, 3, 4, 5});
      chk(clash_in == 3, "R9 example clash_in", clash_in, 3);
      chk(clash_out == 0, "R10 example clash_out", clash_out, 0);
      beat(4'b0001, 4'b0000);
      @(negedge clk);
      chk(clash_in == 3, "R6 beat after strobe ignored", clash_in, 3);
      chk(out_valid == 0, "R6 no new output after strobe", out_valid, 0);

      // 01-heavy, no 11, with backpressure: single pick then drain
      do_reset();
      bp_mode = 1;
      beat(4'b0000, 4'b1000); beat(4'b0000, 4'b1000); beat(4'b0001, 4'b0000);
      beat(4'b0000, 4'b0000); beat(4'b0000, 4'b1000); beat(4'b0000, 4'b1000);
      end_load();
      wait_done();
      cmp_seq("R3 R5 drain order", '{3, 0, 2, 1, 4, 5});

      // overflow: 10 beats, last two (group 00) must be dropped; no 00/01 kept
      do_reset();
      beat(4'b0001, 4'b0000); beat(4'b0001, 4'b1000); beat(4'b0001, 4'b0000);
      beat(4'b0001, 4'b1000); beat(4'b0001, 4'b0000); beat(4'b0001, 4'b0000);
      beat(4'b0001, 4'b1000); beat(4'b0001, 4'b0000);
      beat(4'b0000, 4'b0000);
      ld_done = 1; ld_valid = 1; ld_vec = 4'b0000; ld_resp = 4'b0000;
      @(negedge clk);
      ld_done = 0; ld_valid = 0;
      wait_done();
      cmp_seq("R4 R6 overflow order", '{1, 3, 6, 0, 2, 4, 5, 7});
      bp_mode = 0;

      // strobe beat accepted; single pair
      do_reset();
      ld_done = 1; ld_valid = 1; ld_vec = 4'b0000; ld_resp = 4'b1000;
      @(negedge clk);
      ld_done = 0; ld_valid = 0;
      wait_done();
      cmp_seq("R6 beat with strobe", '{0});

      // empty load
      do_reset();
      end_load();
      chk(out_done == 1, "R8 empty load done", out_done, 1);
      chk(out_valid == 0, "R7 empty load no valid", out_valid, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule